// File: doc/BRIEF.md
# Bus clock prescaler tree

The block runs on one fast system clock and turns it into a set of clock-enable strobes. A high-speed bus strobe is divided from the system clock. Two peripheral bus strobes are divided from the high-speed strobe. Each peripheral domain also has a timer strobe, and there is a slow tick. Each divider is a power-of-two counter. A domain strobe is a one-cycle pulse that fires when that domain's counter wraps.

Divide ratios come from code fields in a configuration register. Three enable registers, one per domain, gate the per-peripheral enables. All four registers are written over a simple address, data and strobe port, and the addressed register reads back one cycle later.

A ratio change never cuts a pulse period short, because each counter picks up its new limit only when it wraps. Logic that runs on the system clock and qualifies its flops with these strobes sees clean, evenly spaced enables.

Top module: `bus_prescale_tree`

## Requirements
- R1: After a synchronous reset every register holds zero, and `hs_en`, `pa_en`, `pb_en`, `pa_tmr_en` and `pb_tmr_en` are high in every cycle until a ratio is changed.
- R2: The high-speed code (config bits [7:4]) maps values 0 to 7 to divide-by-1, 8 to 11 to 2, 4, 8 and 16, and 12 to 15 to 64, 128, 256 and 512. Divide-by-32 cannot be selected.
- R3: Each peripheral code maps values 0 to 3 to divide-by-1 and 4 to 7 to 2, 4, 8 and 16. Domain A uses config bits [12:10] and domain B uses bits [15:13].
- R4: The peripheral dividers count `hs_en` pulses, not system cycles. A peripheral strobe is only ever high in a cycle where `hs_en` is high.
- R5: When a peripheral code is 4 or more, that domain's timer strobe pulses twice per domain period, at the halfway count and at the wrap. When the code is below 4, the timer strobe equals the domain strobe.
- R6: `tick_en` pulses on every eighth `hs_en` pulse. `fclk_en` equals `hs_en` in every cycle.
- R7: A new code is used only from the next wrap of the affected counter. The period that is running when the write lands completes at the old length.
- R8: Each bit of a gate output is the domain strobe ANDed with the matching enable-register bit. Only the bits set in that domain's implemented mask (defaults 0x0000F0FF for the high-speed domain, 0x0F7FC03F for A, 0x00773F33 for B) are stored. All other bits read as zero and never pulse.
- R9: The register at address 0 is configuration, and only bits [1:0], [7:4] and [15:10] are stored. Addresses 1, 2 and 3 are the enable registers of the high-speed domain, domain A and domain B. `cfg_rdata` returns the register addressed in the previous cycle, holding its value from before any write in that same cycle.
- R10: The source-select field (config bits [1:0]) is stored and read back but has no effect on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address for write and read |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Read data for the address of the previous cycle |
| hs_en | output | 1 | High-speed bus enable strobe |
| fclk_en | output | 1 | Free-running enable at the high-speed rate |
| tick_en | output | 1 | Tick strobe at one eighth of the high-speed rate |
| pa_en | output | 1 | Peripheral domain A enable strobe |
| pa_tmr_en | output | 1 | Domain A timer enable strobe |
| pb_en | output | 1 | Peripheral domain B enable strobe |
| pb_tmr_en | output | 1 | Domain B timer enable strobe |
| hs_gate | output | REG_W | Per-peripheral gated enables, high-speed domain |
| pa_gate | output | REG_W | Per-peripheral gated enables, domain A |
| pb_gate | output | REG_W | Per-peripheral gated enables, domain B |

## Verification
The assertions assume reset is high from time zero and that the register port changes only between clock edges. Under those conditions a counter can never run past its limit, and a limit can change only in the cycle after a wrap. The stimulus drives every input on the falling edge and holds reset for several cycles first. It then writes every high-speed code and every pair of peripheral codes, and follows that with random writes that often land in the middle of a period, to exercise the wrap-time update.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

    localparam int HS_CNT_W = 9;
    localparam int PB_CNT_W = 4;

    localparam logic [1:0] ADDR_CFG   = 2'd0;
    localparam logic [1:0] ADDR_EN_HS = 2'd1;
    localparam logic [1:0] ADDR_EN_PA = 2'd2;
    localparam logic [1:0] ADDR_EN_PB = 2'd3;

    // configuration word, most significant field first
    typedef struct packed {
        logic [2:0] pb_code;
        logic [2:0] pa_code;
        logic [1:0] rsv_hi;
        logic [3:0] hs_code;
        logic [1:0] rsv_lo;
        logic [1:0] src_sel;
    } cfg_t;

    localparam logic [15:0] CFG_MASK = 16'hFCF3;

    // terminal count of the high-speed counter for a code
    function automatic logic [HS_CNT_W-1:0] hs_lim(input logic [3:0] code);
        logic [3:0] sh;
        if (!code[3])      sh = 4'd0;
        else if (!code[2]) sh = {2'b00, code[1:0]} + 4'd1;
        else               sh = {2'b00, code[1:0]} + 4'd6;
        return (HS_CNT_W'(1) << sh) - HS_CNT_W'(1);
    endfunction

    // terminal count of a peripheral counter for a code
    function automatic logic [PB_CNT_W-1:0] pb_lim(input logic [2:0] code);
        logic [3:0] sh;
        sh = code[2] ? ({2'b00, code[1:0]} + 4'd1) : 4'd0;
        return (PB_CNT_W'(1) << sh) - PB_CNT_W'(1);
    endfunction

endpackage

// File: rtl/prescale_div.sv
module prescale_div #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_en,
    input  logic [CNT_W-1:0] nxt_lim,
    output logic             out_en,
    output logic             half_en
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             at_wrap;

    assign at_wrap = (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= '0;
        end else if (in_en) begin
            if (at_wrap) begin
                cnt <= '0;
                lim <= nxt_lim;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign out_en  = in_en & at_wrap;
    assign half_en = in_en & (at_wrap | (cnt == (lim >> 1)));

    // R7
    lim_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lim) |-> $past(out_en));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);

endmodule

// File: rtl/prescale_regs.sv
module prescale_regs
    import prescale_pkg::*;
#(
    parameter int               ADDR_W  = 2,
    parameter int               REG_W   = 32,
    parameter logic [REG_W-1:0] HS_IMPL = '1,
    parameter logic [REG_W-1:0] PA_IMPL = '1,
    parameter logic [REG_W-1:0] PB_IMPL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [3:0]        hs_code,
    output logic [2:0]        pa_code,
    output logic [2:0]        pb_code,
    output logic [REG_W-1:0]  en_hs,
    output logic [REG_W-1:0]  en_pa,
    output logic [REG_W-1:0]  en_pb
);
    cfg_t             cfg_q;
    logic [REG_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            en_hs <= '0;
            en_pa <= '0;
            en_pb <= '0;
        end else if (we) begin
            case (2'(addr))
                ADDR_CFG:   cfg_q <= cfg_t'(wdata[15:0] & CFG_MASK);
                ADDR_EN_HS: en_hs <= wdata & HS_IMPL;
                ADDR_EN_PA: en_pa <= wdata & PA_IMPL;
                default:    en_pb <= wdata & PB_IMPL;
            endcase
        end
    end

    always_comb begin
        case (2'(addr))
            ADDR_CFG:   rd_mux = {{(REG_W-16){1'b0}}, cfg_q};
            ADDR_EN_HS: rd_mux = en_hs;
            ADDR_EN_PA: rd_mux = en_pa;
            default:    rd_mux = en_pb;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_mux;
    end

    assign hs_code = cfg_q.hs_code;
    assign pa_code = cfg_q.pa_code;
    assign pb_code = cfg_q.pb_code;

    // R8
    en_impl_chk: assert property (@(posedge clk) disable iff (rst)
        ((en_hs & ~HS_IMPL) == '0) && ((en_pa & ~PA_IMPL) == '0) && ((en_pb & ~PB_IMPL) == '0));

endmodule

// File: rtl/bus_prescale_tree.sv
module bus_prescale_tree
    import prescale_pkg::*;
#(
    parameter int               ADDR_W    = 2,
    parameter int               REG_W     = 32,
    parameter int               TICK_LOG2 = 3,
    parameter logic [REG_W-1:0] HS_IMPL   = 32'h0000_F0FF,
    parameter logic [REG_W-1:0] PA_IMPL   = 32'h0F7F_C03F,
    parameter logic [REG_W-1:0] PB_IMPL   = 32'h0077_3F33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              hs_en,
    output logic              fclk_en,
    output logic              tick_en,
    output logic              pa_en,
    output logic              pa_tmr_en,
    output logic              pb_en,
    output logic              pb_tmr_en,
    output logic [REG_W-1:0]  hs_gate,
    output logic [REG_W-1:0]  pa_gate,
    output logic [REG_W-1:0]  pb_gate
);
    logic [3:0]           hs_code;
    logic [2:0]           pa_code;
    logic [2:0]           pb_code;
    logic [REG_W-1:0]     en_hs;
    logic [REG_W-1:0]     en_pa;
    logic [REG_W-1:0]     en_pb;
    logic                 hs_half;
    logic [TICK_LOG2-1:0] tick_cnt;

    prescale_regs #(
        .ADDR_W(ADDR_W), .REG_W(REG_W),
        .HS_IMPL(HS_IMPL), .PA_IMPL(PA_IMPL), .PB_IMPL(PB_IMPL)
    ) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .hs_code(hs_code), .pa_code(pa_code), .pb_code(pb_code),
        .en_hs(en_hs), .en_pa(en_pa), .en_pb(en_pb)
    );

    prescale_div #(.CNT_W(HS_CNT_W)) u_hs_div (
        .clk(clk), .rst(rst), .in_en(1'b1), .nxt_lim(hs_lim(hs_code)),
        .out_en(hs_en), .half_en(hs_half)
    );

    prescale_div #(.CNT_W(PB_CNT_W)) u_pa_div (
        .clk(clk), .rst(rst), .in_en(hs_en), .nxt_lim(pb_lim(pa_code)),
        .out_en(pa_en), .half_en(pa_tmr_en)
    );

    prescale_div #(.CNT_W(PB_CNT_W)) u_pb_div (
        .clk(clk), .rst(rst), .in_en(hs_en), .nxt_lim(pb_lim(pb_code)),
        .out_en(pb_en), .half_en(pb_tmr_en)
    );

    always_ff @(posedge clk) begin
        if (rst)        tick_cnt <= '0;
        else if (hs_en) tick_cnt <= tick_cnt + TICK_LOG2'(1);
    end

    assign tick_en = hs_en & (&tick_cnt);
    assign fclk_en = hs_en | (hs_half & hs_en);

    assign hs_gate = {REG_W{hs_en}} & en_hs;
    assign pa_gate = {REG_W{pa_en}} & en_pa;
    assign pb_gate = {REG_W{pb_en}} & en_pb;

    // R1
    reset_rate_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hs_en && pa_en && pb_en && pa_tmr_en && pb_tmr_en));

    // R4
    pa_nested_chk: assert property (@(posedge clk) disable iff (rst)
        (pa_en || pb_en) |-> hs_en);

    // R5
    tmr_nested_chk: assert property (@(posedge clk) disable iff (rst)
        (pa_en |-> pa_tmr_en) and (pb_en |-> pb_tmr_en));

    // R6
    tick_nested_chk: assert property (@(posedge clk) disable iff (rst)
        tick_en |-> hs_en);

    // R8
    gate_impl_chk: assert property (@(posedge clk) disable iff (rst)
        ((pa_gate & ~PA_IMPL) == '0) && ((pb_gate & ~PB_IMPL) == '0) && ((hs_gate & ~HS_IMPL) == '0));

endmodule

// File: tb/tb_bus_prescale_tree.sv
`timescale 1ns/1ps
module tb_bus_prescale_tree;
    localparam logic [31:0] M_HS = 32'h0000_F0FF;
    localparam logic [31:0] M_PA = 32'h0F7F_C03F;
    localparam logic [31:0] M_PB = 32'h0077_3F33;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, hs_gate, pa_gate, pb_gate;
    logic        hs_en, fclk_en, tick_en, pa_en, pa_tmr_en, pb_en, pb_tmr_en;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    bus_prescale_tree dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .hs_en(hs_en), .fclk_en(fclk_en), .tick_en(tick_en),
        .pa_en(pa_en), .pa_tmr_en(pa_tmr_en), .pb_en(pb_en), .pb_tmr_en(pb_tmr_en),
        .hs_gate(hs_gate), .pa_gate(pa_gate), .pb_gate(pb_gate)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic int hs_ratio(input logic [3:0] c);
        case (c)
            4'h8: return 2;   4'h9: return 4;   4'hA: return 8;   4'hB: return 16;
            4'hC: return 64;  4'hD: return 128; 4'hE: return 256; 4'hF: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int pb_ratio(input logic [2:0] c);
        case (c)
            3'd4: return 2; 3'd5: return 4; 3'd6: return 8; 3'd7: return 16;
            default: return 1;
        endcase
    endfunction

    int hcnt, hlim, acnt, alim, bcnt, blim, tcnt;
    logic [15:0] m_cfg;
    logic [31:0] m_ehs, m_epa, m_epb, m_rd;
    bit m_init = 1'b0;

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {16'h0, m_cfg};
            2'd1: return m_ehs;
            2'd2: return m_epa;
            default: return m_epb;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hcnt = 0; hlim = 0; acnt = 0; alim = 0; bcnt = 0; blim = 0; tcnt = 0;
            m_cfg = '0; m_ehs = '0; m_epa = '0; m_epb = '0; m_rd = '0;
            m_init = 1'b1;
        end else begin
            automatic bit hp = (hcnt == hlim);
            m_rd = m_read(cfg_addr);
            if (hp) begin
                tcnt = (tcnt + 1) % 8;
                if (acnt == alim) begin acnt = 0; alim = pb_ratio(m_cfg[12:10]) - 1; end
                else acnt++;
                if (bcnt == blim) begin bcnt = 0; blim = pb_ratio(m_cfg[15:13]) - 1; end
                else bcnt++;
            end
            if (hp) begin hcnt = 0; hlim = hs_ratio(m_cfg[7:4]) - 1; end
            else hcnt++;
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_cfg = cfg_wdata[15:0] & 16'hFCF3;
                    2'd1: m_ehs = cfg_wdata & M_HS;
                    2'd2: m_epa = cfg_wdata & M_PA;
                    default: m_epb = cfg_wdata & M_PB;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (m_init && !done) begin
            automatic bit hp  = (hcnt == hlim);
            automatic bit ap  = hp && (acnt == alim);
            automatic bit bp  = hp && (bcnt == blim);
            automatic bit at  = hp && ((acnt == alim) || (acnt == alim / 2));
            automatic bit bt  = hp && ((bcnt == blim) || (bcnt == blim / 2));
            automatic bit tk  = hp && (tcnt == 7);
            chk("R2", "hs_en", 32'(hs_en), 32'(hp));
            chk("R6", "fclk_en", 32'(fclk_en), 32'(hp));
            chk("R6", "tick_en", 32'(tick_en), 32'(tk));
            chk("R3", "pa_en", 32'(pa_en), 32'(ap));
            chk("R3", "pb_en", 32'(pb_en), 32'(bp));
            chk("R5", "pa_tmr_en", 32'(pa_tmr_en), 32'(at));
            chk("R5", "pb_tmr_en", 32'(pb_tmr_en), 32'(bt));
            chk("R8", "hs_gate", hs_gate, hp ? m_ehs : 32'h0);
            chk("R8", "pa_gate", pa_gate, ap ? m_epa : 32'h0);
            chk("R8", "pb_gate", pb_gate, bp ? m_epb : 32'h0);
            chk("R9", "cfg_rdata", cfg_rdata, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_hs(output int gap);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!hs_en);
    endtask

    task automatic wait_pa(output int gap);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!pa_en);
    endtask

    task automatic wait_patm(output int gap);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!pa_tmr_en);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int g;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, every domain at full rate
        chk("R1", "hs_en after reset", 32'(hs_en), 32'd1);
        chk("R1", "pa_en after reset", 32'(pa_en), 32'd1);
        chk("R1", "pb_en after reset", 32'(pb_en), 32'd1);
        chk("R1", "tmr after reset", 32'({pa_tmr_en, pb_tmr_en}), 32'd3);
        chk("R1", "rdata after reset", cfg_rdata, 32'd0);
        idle(4);

        // R10: source select alone changes nothing
        wr(2'd0, 32'h0000_0003);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R10", "hs_en with src set", 32'({hs_en, pa_en, pb_en}), 32'd7);
        end
        chk("R10", "src readback", cfg_rdata, 32'h0000_0003);

        // R9 / R8: enable registers and masks
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFF);
        cfg_addr = 2'd0; idle(2);
        chk("R9", "cfg mask readback", cfg_rdata, 32'h0000_FCF3);
        cfg_addr = 2'd2; idle(2);
        chk("R8", "pa enable readback", cfg_rdata, M_PA);
        wr(2'd0, 32'h0);
        idle(600);

        // R2: every high-speed code
        for (int c = 0; c < 16; c++) begin
            wr(2'd0, 32'(c) << 4);
            idle(1100);
        end

        // R3: every pair of peripheral codes
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                wr(2'd0, (32'(b) << 13) | (32'(a) << 10));
                idle(80);
            end

        // R4 / R5: peripheral counts hs pulses
        wr(2'd0, 32'h0000_1080);
        idle(40);
        wait_pa(g); wait_pa(g);
        chk("R4", "pa gap at hs/2 pa/2", 32'(g), 32'd4);
        wait_patm(g); wait_patm(g);
        chk("R5", "pa timer gap", 32'(g), 32'd2);

        // R7: change mid-period
        wr(2'd0, 32'h0000_00B0);
        idle(40);
        wait_hs(g); wait_hs(g);
        chk("R7", "settled gap 16", 32'(g), 32'd16);
        idle(3);
        wr(2'd0, 32'h0000_0080);
        wait_hs(g);
        chk("R7", "running period kept", 32'(g + 5), 32'd16);
        wait_hs(g);
        chk("R7", "new period", 32'(g), 32'd2);

        // random writes and reads, often mid-period
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            cfg_addr = 2'($urandom_range(0, 3));
            cfg_we   = ($urandom_range(0, 7) == 0);
            cfg_wdata = $urandom();
            if (cfg_addr == 2'd0 && $urandom_range(0, 1) == 1) cfg_wdata[7] = 1'b0;
        end
        cfg_we = 1'b0;
        idle(4);
        finish_run();
    end
endmodule